// File: doc/BRIEF.md
# SMBus Clock-Low Timeout and Bus-Idle Monitor

This block watches the already-synchronized clock and data lines of a two-wire slave port. It raises a single-cycle reset request towards the slave protocol engine when either of two timing rules is broken. The first rule is that the clock line must not stay low for longer than the long timeout (30 ms by default). The second rule is that the bus is considered idle, and the protocol engine is returned to its idle state, when both lines have stayed high for longer than the short idle window (200 µs by default).

Both timers are measured in system clock cycles. Their limits are derived from a clock-frequency parameter and two interval parameters given in microseconds. One enable input, driven from a configuration bit that clears at reset, switches both timers on or off together. When the enable is low the block behaves like a plain I2C slave would: nothing ever resets the interface. Register storage, the protocol state machine and master-side recovery belong to other blocks.

Top module: `smb_line_watchdog`

## Requirements
- R1: After the synchronous active-low reset, `slave_reset_o` is 0 and both interval counts start from zero. A line that was already in a timing condition during reset needs a full interval, counted from the first edge after reset, before it causes a pulse.
- R2: With `enable_i` = 1, `slave_reset_o` is 1 during the cycle that follows the LOW_TICKS-th consecutive rising clock edge at which `scl_i` is sampled 0. LOW_TICKS = CLK_HZ × LOW_US / 1,000,000 (1,500,000 for the defaults).
- R3: If `scl_i` is sampled 1 before the low count reaches LOW_TICKS, no pulse is raised. The next low period counts again from zero.
- R4: With `enable_i` = 1, `slave_reset_o` is 1 during the cycle that follows the IDLE_TICKS-th consecutive rising edge at which `scl_i` and `sda_i` are both sampled 1. IDLE_TICKS = CLK_HZ × IDLE_US / 1,000,000 (10,000 for the defaults).
- R5: A change on either line that breaks the both-high condition restarts the idle count from zero. A short dip on `sda_i` therefore delays the idle pulse by a full window.
- R6: Every pulse lasts exactly one cycle, and each expired interval gives exactly one pulse. Staying in the same condition after expiry gives no further pulse until the condition is broken and a new full interval elapses.
- R7: While `enable_i` is 0, `slave_reset_o` stays 0 however long either condition lasts.
- R8: Sampling `enable_i` = 0 clears both counts. After `enable_i` returns to 1, a full interval is needed before the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Timeout enable from the configuration bit; 1 turns on both timers |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line |
| slave_reset_o | output | 1 | One-cycle reset request to the slave protocol engine |

## Verification
The hardest situation to reach from the ports is the exact expiry edge of the long clock-low window. At the real system clock it lies 1.5 million cycles away, so the bench scales CLK_HZ down to 50 kHz. This brings LOW_TICKS to 1500 and IDLE_TICKS to 10 while the derivation stays the same. Directed runs then stop one edge short of each limit and one edge past it. They also cut the enable in the middle of a count and then restore it. Random segments have lengths drawn around both limits and are compared cycle by cycle against a bench model of the requirements.

// File: rtl/smb_wd_pkg.sv
// Package: shared constants and helpers for the SMBus line watchdog.
// Assumes interval parameters are given in microseconds and the clock in Hz.
package smb_wd_pkg;

    // Index of each supervised condition; the order picks the timer instance.
    localparam int unsigned COND_CLK_LOW = 0;
    localparam int unsigned COND_IDLE    = 1;
    localparam int unsigned NUM_COND     = 2;

    // Converts an interval in microseconds into whole system clock cycles.
    function automatic int unsigned us_to_ticks(input longint unsigned clk_hz,
                                                input longint unsigned us);
        longint unsigned prod;
        prod = (clk_hz * us) / 64'd1_000_000;
        return int'(prod);
    endfunction

endpackage

// File: rtl/smb_line_cond.sv
// Module: smb_line_cond
// Decodes the two supervised bus conditions from the synchronized lines.
// Assumes scl_i and sda_i are already synchronized to clk_i.
module smb_line_cond
    import smb_wd_pkg::*;
(
    input  logic                scl_i,
    input  logic                sda_i,
    output logic [NUM_COND-1:0] cond_o
);

    // Condition vector: clock held low, or both lines released high.
    always_comb begin
        cond_o               = '0;
        cond_o[COND_CLK_LOW] = ~scl_i;
        cond_o[COND_IDLE]    = scl_i & sda_i;
    end

endmodule

// File: rtl/smb_interval_timer.sv
// Module: smb_interval_timer
// Counts consecutive cycles of one condition and emits a single-cycle
// pulse when the count first reaches LIMIT. The count saturates at LIMIT,
// so one unbroken condition gives one pulse. Breaking the condition or
// dropping the enable clears the count.
// Assumes LIMIT >= 2.
module smb_interval_timer #(
    parameter int unsigned LIMIT = 1500
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic cond_i,
    output logic fire_o
);

    localparam int unsigned CW      = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_C = CW'(LIMIT);
    localparam logic [CW-1:0] PRE_C = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          fire_q;

    // Counter: clear when off or condition broken, else count up to LIMIT.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !en_i || !cond_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM_C) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Pulse register: set only on the edge at which the count reaches LIMIT.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !en_i || !cond_i) begin
            fire_q <= 1'b0;
        end else begin
            fire_q <= (cnt_q == PRE_C);
        end
    end

    assign fire_o = fire_q;

    // R6: a pulse never lasts more than one cycle.
    p_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_q |=> !fire_q);

    // R6: the saturating count never passes its limit.
    p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LIM_C);

    // R8: a disabled cycle leaves the count at zero.
    p_clear_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (cnt_q == '0));

    // R3 / R5: a broken condition restarts the count.
    p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !cond_i) |=> (cnt_q == '0));

    // R2 / R4: a pulse only follows a cycle that held the condition.
    p_fire_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_q |-> ($past(cond_i) && $past(en_i)));

endmodule

// File: rtl/smb_line_watchdog.sv
// Module: smb_line_watchdog (top)
// Supervises the synchronized bus lines with a long clock-low timer and a
// short bus-idle timer, both gated by one enable. It requests a
// single-cycle reset of the slave protocol engine when either expires.
// Assumes synchronized inputs and an enable that clears at reset.
module smb_line_watchdog
    import smb_wd_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned LOW_US  = 30_000,
    parameter int unsigned IDLE_US = 200
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic slave_reset_o
);

    localparam int unsigned LOW_TICKS  = us_to_ticks(64'(CLK_HZ), 64'(LOW_US));
    localparam int unsigned IDLE_TICKS = us_to_ticks(64'(CLK_HZ), 64'(IDLE_US));

    logic [NUM_COND-1:0] cond;
    logic [NUM_COND-1:0] fire;

    smb_line_cond u_cond (
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .cond_o (cond)
    );

    // One interval timer per supervised condition, limit chosen by index.
    for (genvar g = 0; g < NUM_COND; g++) begin : g_timer
        localparam int unsigned LIM = (g == COND_CLK_LOW) ? LOW_TICKS : IDLE_TICKS;
        smb_interval_timer #(.LIMIT(LIM)) u_timer (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .en_i   (enable_i),
            .cond_i (cond[g]),
            .fire_o (fire[g])
        );
    end

    // Merge: either expiry requests the slave interface reset.
    always_comb begin
        slave_reset_o = |fire;
    end

    // R7: no request follows a cycle with the timers disabled.
    p_silent_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> !slave_reset_o);

    // R1: the request is low in the first cycle after reset.
    p_reset_quiet_r1: assert property (@(posedge clk_i)
        !rst_ni |=> !slave_reset_o);

    // R2 / R4: the two expiries are exclusive, never both at once.
    p_exclusive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(fire));

endmodule

// File: tb/smb_line_watchdog_test.sv
// Bench for smb_line_watchdog: directed corner cases and seeded random
// segments, compared every cycle against a model of the requirements.
module smb_line_watchdog_test;

    localparam int unsigned CLK_HZ  = 50_000;
    localparam int unsigned LOW_US  = 30_000;
    localparam int unsigned IDLE_US = 200;
    localparam int LOW  = 1500;   // CLK_HZ*LOW_US/1e6
    localparam int IDLE = 10;     // CLK_HZ*IDLE_US/1e6

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic rst_o;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int lc = 0;
    int ic = 0;
    logic exp_q = 1'b0;
    string cur_tag = "R1";
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    smb_line_watchdog #(.CLK_HZ(CLK_HZ), .LOW_US(LOW_US), .IDLE_US(IDLE_US)) uut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .enable_i      (en),
        .scl_i         (scl),
        .sda_i         (sda),
        .slave_reset_o (rst_o)
    );

    function automatic int bump(input int c, input int lim);
        return (c > lim) ? c : c + 1;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    // Model of the requirements, updated at every rising edge.
    always @(posedge clk) begin
        if (!rst_n || !en) begin
            lc = 0; ic = 0; exp_q = 1'b0;
        end else begin
            lc = scl ? 0 : bump(lc, LOW);
            ic = (scl && sda) ? bump(ic, IDLE) : 0;
            exp_q = (lc == LOW) || (ic == IDLE);
        end
    end

    // Cycle compare and pulse tally, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            check(rst_o === exp_q, cur_tag, int'(rst_o), int'(exp_q));
            if (rst_o === 1'b1) pulses++;
        end
    end

    task automatic run(input logic s, input logic d, input logic e, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            scl = s; sda = d; en = e;
        end
    endtask

    task automatic expect_pulses(input int base, input int want, input string tag);
        @(posedge clk);
        check((pulses - base) == want, tag, pulses - base, want);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 190_000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int base;
        void'($urandom(32'd20240607));

        // R1: reset holds the output low even with the clock line low.
        cur_tag = "R1";
        scl = 1'b0; sda = 1'b1; en = 1'b1;
        repeat (6) @(negedge clk);
        check(rst_o === 1'b0, "R1 reset state", int'(rst_o), 0);
        rst_n = 1'b1;
        base = pulses;
        run(1'b0, 1'b1, 1'b1, LOW - 1);
        expect_pulses(base, 0, "R1 full interval after reset");

        // R2: the LOW-th low edge expires; R6: holding on gives no more.
        cur_tag = "R2";
        base = pulses;
        run(1'b0, 1'b1, 1'b1, 3);
        expect_pulses(base, 1, "R2 clock-low expiry");
        cur_tag = "R6";
        base = pulses;
        run(1'b0, 1'b1, 1'b1, 2 * LOW);
        expect_pulses(base, 0, "R6 no repeat while held low");

        // R3: one edge short of the limit, then release.
        cur_tag = "R3";
        run(1'b1, 1'b0, 1'b1, 3);
        base = pulses;
        run(1'b0, 1'b0, 1'b1, LOW - 1);
        run(1'b1, 1'b0, 1'b1, 2);
        run(1'b0, 1'b0, 1'b1, LOW - 1);
        run(1'b1, 1'b0, 1'b1, 2);
        expect_pulses(base, 0, "R3 short low periods");

        // R4: idle one short, then exactly at the limit.
        cur_tag = "R4";
        base = pulses;
        run(1'b1, 1'b1, 1'b1, IDLE - 1);
        run(1'b1, 1'b0, 1'b1, 1);
        expect_pulses(base, 0, "R4 idle one short");
        base = pulses;
        run(1'b1, 1'b1, 1'b1, IDLE + 2);
        expect_pulses(base, 1, "R4 idle expiry");

        // R5: an SDA dip restarts the idle window.
        cur_tag = "R5";
        run(1'b1, 1'b0, 1'b1, 2);
        base = pulses;
        run(1'b1, 1'b1, 1'b1, IDLE - 3);
        run(1'b1, 1'b0, 1'b1, 1);
        run(1'b1, 1'b1, 1'b1, IDLE - 3);
        run(1'b0, 1'b1, 1'b1, 1);
        expect_pulses(base, 0, "R5 dip restarts idle");

        // R6: long idle gives one single-cycle pulse.
        cur_tag = "R6";
        run(1'b1, 1'b0, 1'b1, 2);
        base = pulses;
        run(1'b1, 1'b1, 1'b1, 5 * IDLE);
        expect_pulses(base, 1, "R6 one idle pulse");

        // R7: disabled, neither condition ever fires.
        cur_tag = "R7";
        base = pulses;
        run(1'b0, 1'b0, 1'b0, 2 * LOW + 5);
        run(1'b1, 1'b1, 1'b0, 10 * IDLE);
        expect_pulses(base, 0, "R7 disabled silent");

        // R8: a one-cycle disable in mid-count clears the clock-low count.
        cur_tag = "R8";
        base = pulses;
        run(1'b0, 1'b0, 1'b1, LOW - 100);
        run(1'b0, 1'b0, 1'b0, 1);
        run(1'b0, 1'b0, 1'b1, LOW - 100);
        expect_pulses(base, 0, "R8 count cleared by disable");
        base = pulses;
        run(1'b0, 1'b0, 1'b1, 200);
        expect_pulses(base, 1, "R8 full interval after re-enable");

        // Random segments around both limits; the cycle compare checks them.
        cur_tag = "R2/R4 random";
        for (int k = 0; k < 60; k++) begin
            int kind;
            int len;
            logic e;
            kind = int'($urandom % 4);
            e = ($urandom % 10) != 0;
            case (kind)
                0: begin len = LOW - 3 + int'($urandom % 7); run(1'b0, 1'(($urandom)), e, len); end
                1: begin len = IDLE - 3 + int'($urandom % 7); run(1'b1, 1'b1, e, len); end
                2: begin len = 1 + int'($urandom % 5); run(1'(($urandom)), 1'(($urandom)), e, len); end
                default: begin len = 1 + int'($urandom % 40); run(1'b1, 1'b0, e, len); end
            endcase
        end
        run(1'b1, 1'b0, 1'b1, 3);
        finish_run();
    end

endmodule